// File: doc/BRIEF.md
# Interrupt Status and Mask Register

This block holds the event flags and interrupt masks of a capacitive-sense measurement unit in one 8-bit word, next to a 6-bit timer preload register. The measurement logic sends four single-cycle event strobes: an input rising edge, a low-counter carry-out, a high-counter carry-out, and the end of a pulse-width or period measurement. While the block is enabled, each strobe sets a sticky flag. Software reads the flags and clears them by writing zero to them.

A single-cycle write port and a combinational read port each select one of two words with a 1-bit address. Address 0 is the status/mask word and address 1 is the timer preload. A registered interrupt output goes high when any flag is set and its mask bit is set.

Software can change the masks without losing pending flags. To do so it writes ones to all four flag positions in the same write.

Top module: `sr_stat_mask`

## Requirements
- R1: After reset, every status flag and mask bit is 0, the timer preload is 0, and `irq_o` is 0.
- R2: Reading address 0 returns status in bits 7..4 and masks in bits 3..0. Bit 7 is the input-edge flag (`evt_i[3]`), bit 6 the low carry (`evt_i[2]`), bit 5 the high carry (`evt_i[1]`) and bit 4 measurement done (`evt_i[0]`). Mask bit k (k = 0..3) belongs to flag bit 4+k. Reading address 1 returns `{2'b00, preload}`.
- R3: While `en_i` is 1, a 1 on `evt_i[k]` at a clock edge sets flag k. The flag stays set until it is cleared.
- R4: A write to address 0 clears each flag whose data bit (7..4) is 0. A data bit of 1 leaves its flag unchanged.
- R5: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: While `en_i` is 0, all flags are held at 0 from the next edge on, and events are ignored.
- R7: A write to address 0 loads the masks from data bits 3..0, whether or not the block is enabled.
- R8: At each clock edge, `irq_o` takes the OR over k of (flag k AND mask k), using the values from before that edge. `irq_o` therefore lags a flag or mask change by one cycle.
- R9: A write to address 1 loads the preload from data bits 5..0 and leaves the flags and masks unchanged. A write to address 0 leaves the preload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable and running |
| evt_i | input | 4 | Event strobes: [3] edge, [2] low carry, [1] high carry, [0] done |
| wr_en_i | input | 1 | Write strobe, one cycle |
| wr_addr_i | input | 1 | Write select: 0 status/mask, 1 preload |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read select: 0 status/mask, 1 preload |
| rd_data_o | output | 8 | Read data |
| tmr_preload_o | output | 6 | Timer initial count value |
| irq_o | output | 1 | Block interrupt, registered |

## Verification
The assertions assume that the event strobes, the write strobe, the address and the write data are stable at each rising edge. They also assume that the enable changes only at clock edges, so each edge sees one clean combination of enable, events and write. The stimulus drives every input one nanosecond after a rising edge. Over the random phase it keeps the enable mostly high, with short disabled stretches, and keeps events sparse, so that flags are set, cleared and collide with clearing writes many times.

// File: rtl/sr_pkg.sv
package sr_pkg;
  parameter int unsigned NUM_EVT = 4;
  parameter int unsigned TMR_W   = 6;
  localparam int unsigned DATA_W = 2 * NUM_EVT;
  localparam int unsigned PAD_W  = DATA_W - TMR_W;

  typedef enum logic {
    ADDR_STAT  = 1'b0,
    ADDR_TIMER = 1'b1
  } reg_addr_e;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/sr_flag_bit.sv
module sr_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;

  // event has priority over a clearing write
  always_comb begin
    if (!en_i)      flag_d = 1'b0;
    else if (evt_i) flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= flag_d;
  end
endmodule

// File: rtl/sr_status_flags.sv
module sr_status_flags
  import sr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  evt_vec_t evt_i,
  input  logic     wr_i,
  input  evt_vec_t wr_bits_i,
  output evt_vec_t status_o
);
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
    sr_flag_bit i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .evt_i  (evt_i[k]),
      .clr_i  (wr_i && !wr_bits_i[k]),
      .flag_o (status_o[k])
    );
  end
endmodule

// File: rtl/sr_load_reg.sv
module sr_load_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/sr_irq_gen.sv
module sr_irq_gen
  import sr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t status_i,
  input  evt_vec_t mask_i,
  output logic     irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status_i & mask_i);
  end
endmodule

// File: rtl/sr_stat_mask.sv
module sr_stat_mask
  import sr_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [sr_pkg::NUM_EVT-1:0] evt_i,
  input  logic                     wr_en_i,
  input  logic                     wr_addr_i,
  input  logic [sr_pkg::DATA_W-1:0]  wr_data_i,
  input  logic                     rd_addr_i,
  output logic [sr_pkg::DATA_W-1:0]  rd_data_o,
  output logic [sr_pkg::TMR_W-1:0]   tmr_preload_o,
  output logic                     irq_o
);
  evt_vec_t           status_q;
  evt_vec_t           mask_q;
  logic [TMR_W-1:0]   tmr_q;
  logic               wr_stat;
  logic               wr_tmr;

  assign wr_stat = wr_en_i && (wr_addr_i == ADDR_STAT);
  assign wr_tmr  = wr_en_i && (wr_addr_i == ADDR_TIMER);

  sr_status_flags i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .evt_i     (evt_i),
    .wr_i      (wr_stat),
    .wr_bits_i (wr_data_i[DATA_W-1:NUM_EVT]),
    .status_o  (status_q)
  );

  sr_load_reg #(.W(NUM_EVT)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (wr_stat),
    .d_i    (wr_data_i[NUM_EVT-1:0]),
    .q_o    (mask_q)
  );

  sr_load_reg #(.W(TMR_W)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (wr_tmr),
    .d_i    (wr_data_i[TMR_W-1:0]),
    .q_o    (tmr_q)
  );

  sr_irq_gen i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );

  assign rd_data_o     = (rd_addr_i == ADDR_TIMER) ? {{PAD_W{1'b0}}, tmr_q}
                                                   : {status_q, mask_q};
  assign tmr_preload_o = tmr_q;
endmodule

// File: rtl/sr_stat_mask_chk.sv
module sr_stat_mask_chk
  import sr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               wr_en_i,
  input logic               wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] status_q,
  input logic [NUM_EVT-1:0] mask_q,
  input logic [TMR_W-1:0]   tmr_q
);
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R3

  AST_ZERO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_en_i && !wr_addr_i) |=>
      ((status_q & ~($past(wr_data_i[DATA_W-1:NUM_EVT]) | $past(evt_i))) == '0)); // R4

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(wr_en_i && !wr_addr_i) && evt_i == '0) |=> $stable(status_q)); // R3

  AST_DISABLED_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (status_q == '0)); // R6

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i) |=> (mask_q == $past(wr_data_i[NUM_EVT-1:0]))); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(status_q) & $past(mask_q)))); // R8

  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i) |=> $stable(tmr_q)); // R9
endmodule

bind sr_stat_mask sr_stat_mask_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .evt_i     (evt_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .tmr_q     (tmr_q)
);

// File: tb/test_sr_stat_mask.sv
`timescale 1ns/1ps
module test_sr_stat_mask;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] evt_i = '0;
  logic       wr_en_i = 1'b0;
  logic       wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_addr_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [5:0] tmr_preload_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_st = '0, m_mk = '0;
  logic [5:0] m_tm = '0;
  logic       m_irq = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sr_stat_mask i_sr_stat_mask (.*);

  function automatic logic [3:0] nxt_st(logic en, logic [3:0] ev, logic wr0,
                                        logic [3:0] hi, logic [3:0] st);
    logic [3:0] clr;
    clr = wr0 ? ~hi : 4'h0;
    return en ? ((st & ~clr) | ev) : 4'h0;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    rd_addr_i = 1'b0; #0.5;
    chk({tag, " word0"}, rd_data_o, {m_st, m_mk});
    rd_addr_i = 1'b1; #0.5;
    chk({tag, " word1"}, rd_data_o, {2'b00, m_tm});
    chk({tag, " preload"}, {2'b00, tmr_preload_o}, {2'b00, m_tm});
    chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, m_irq});
  endtask

  task automatic cyc(logic en, logic [3:0] ev, logic we, logic wa, logic [7:0] wd);
    logic wr0;
    en_i = en; evt_i = ev; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    @(posedge clk_i);
    wr0   = we && !wa;
    m_irq = |(m_st & m_mk);
    m_st  = nxt_st(en, ev, wr0, wd[7:4], m_st);
    if (wr0) m_mk = wd[3:0];
    if (we && wa) m_tm = wd[5:0];
    #1;
    evt_i = '0; wr_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk_all("R1 reset");

    cyc(1, 4'b1000, 0, 0, 8'h00); chk_all("R3 set edge flag");
    chk("R2 bit7 edge", rd_data_o & 8'h00, 8'h00);
    rd_addr_i = 0; #0.1; chk("R2 bit7 edge", rd_data_o, 8'h80);
    cyc(1, 4'b0000, 0, 0, 8'h00); chk_all("R3 sticky");
    cyc(1, 4'b0000, 1, 0, 8'hF8); chk_all("R4 ones no effect / R7 mask");
    rd_addr_i = 0; #0.1; chk("R4 ones keep flag", rd_data_o, 8'h88);
    chk("R8 irq lag", {7'd0, irq_o}, 8'h00);
    cyc(1, 4'b0000, 0, 0, 8'h00); chk("R8 irq set", {7'd0, irq_o}, 8'h01);
    cyc(1, 4'b0000, 1, 0, 8'h08); chk_all("R4 zero clears");
    chk("R8 irq still high", {7'd0, irq_o}, 8'h01);
    cyc(1, 4'b0000, 0, 0, 8'h00); chk("R8 irq drops", {7'd0, irq_o}, 8'h00);
    cyc(1, 4'b0001, 1, 0, 8'h08); chk_all("R5 event wins");
    rd_addr_i = 0; #0.1; chk("R5 event wins", rd_data_o, 8'h18);
    cyc(1, 4'b0110, 0, 0, 8'h00); chk_all("R2 carry positions");
    rd_addr_i = 0; #0.1; chk("R2 carry positions", rd_data_o, 8'h78);
    cyc(0, 4'b1111, 0, 0, 8'h00); chk_all("R6 disable clears");
    rd_addr_i = 0; #0.1; chk("R6 disable clears", rd_data_o, 8'h08);
    cyc(0, 4'b1111, 1, 0, 8'hFF); chk_all("R7 mask while disabled");
    rd_addr_i = 0; #0.1; chk("R6 events ignored", rd_data_o, 8'h0F);
    cyc(0, 4'b0000, 1, 1, 8'hFF); chk_all("R9 preload load");
    rd_addr_i = 1; #0.1; chk("R9 preload", rd_data_o, 8'h3F);
    cyc(1, 4'b0000, 1, 1, 8'hC5); chk_all("R9 preload no touch word0");
    cyc(1, 4'b0000, 1, 0, 8'hF3); chk_all("R9 word0 no touch preload");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom();
      cyc((r[3:0] != 4'd0), r[7:4] & r[11:8] & r[15:12], r[16] | r[17], r[18], r[31:24]);
      chk_all("R2/R8 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule